// File: doc/BRIEF.md
# UART Receive Holding Buffer

This block sits between the bit-level receiver of a UART channel and the CPU. The receiver hands it each assembled character through a one-cycle completion strobe. The character arrives with three error flags: parity, framing and break. The block keeps the character in a one-character holding slot, then moves it into a three-entry FIFO. The CPU sees the character at the head of the FIFO on a data port and removes it with a read strobe. Up to four characters can be buffered at once: three in the FIFO and one waiting in the slot.

Continuously driven status outputs show the ready and full conditions, the error flags and a sticky overrun flag. A mode input selects how the error flags are reported. In per-character mode they belong to the head character. In accumulate mode they are the OR of the flags of every character that has reached the head since the last clear-errors command. One interrupt output follows either the ready flag or the full flag, chosen by a select input. An optional automatic flow-control mode drops the request-to-send output when a new start bit is seen while the FIFO is full. It raises the output again once an entry frees up.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, ready_o, full_o, pe_o, fe_o, brk_o, ovr_o, irq_o and data_o are all 0, and rts_o is 1.
- R2: Characters come out on data_o in the order their done_i strobes arrived. A character strobed into an empty buffer makes ready_o high on the second rising edge after the strobe is sampled.
- R3: ready_o is 1 while the FIFO holds at least one character. full_o is 1 while all three FIFO entries are occupied.
- R4: With the FIFO full, a completed character waits in the holding slot. It enters the FIFO on the edge after a pop has freed an entry.
- R5: If done_i arrives while the slot is still waiting on a full FIFO, the waiting character is lost and the new one takes its place, and the FIFO is unchanged. ovr_o is set on the edge where start_i is sampled while a character waits and the FIFO is full and not being popped. ovr_o stays set until cleared.
- R6: With blk_mode_i = 0, pe_o, fe_o and brk_o show the stored flags of the head character, and are 0 when the FIFO is empty.
- R7: With blk_mode_i = 1, pe_o, fe_o and brk_o show the OR of the flags of every character that has become head since the last clear. Popping does not lower them.
- R8: A clr_err_i cycle clears the accumulated flags and ovr_o. The flags of a character becoming head on that same edge are kept after the clear.
- R9: A rd_i strobe with an empty FIFO changes nothing. data_o keeps the last character popped, and ready_o stays 0.
- R10: irq_o equals ready_o when irq_sel_i = 0 and full_o when irq_sel_i = 1.
- R11: With auto_rts_i = 1, rts_o goes to 0 on the edge where start_i is sampled with the FIFO full and not being popped. It returns to 1 on the edge that leaves fewer than three entries. With auto_rts_i = 0, rts_o is 1.
- R12: A pop and a slot-to-FIFO move on the same edge both take effect. The count is unchanged and the moved character lands behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Character-complete strobe from the shift stage |
| char_i | input | 8 | Assembled character |
| pe_i | input | 1 | Parity error of the character |
| fe_i | input | 1 | Framing error of the character |
| brk_i | input | 1 | Break received with the character |
| start_i | input | 1 | Valid start bit detected strobe |
| rd_i | input | 1 | CPU data read strobe, pops the head |
| blk_mode_i | input | 1 | 0 per-character flags, 1 accumulated flags |
| clr_err_i | input | 1 | Clear accumulated flags and overrun |
| irq_sel_i | input | 1 | 0 interrupt on ready, 1 interrupt on full |
| auto_rts_i | input | 1 | Enable automatic RTS control |
| data_o | output | 8 | Head character, or the last popped one when empty |
| ready_o | output | 1 | At least one character held |
| full_o | output | 1 | All FIFO entries held |
| pe_o | output | 1 | Parity error status |
| fe_o | output | 1 | Framing error status |
| brk_o | output | 1 | Break status |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receive interrupt |
| rts_o | output | 1 | Request to send, 1 = asserted |

## Verification
A pointer or count error in the FIFO appears on data_o or ready_o/full_o on the first read after it occurs, as a wrong or repeated character. A slot that drains early, or that is overwritten when it should not be, shows up in the overrun sequence: the wrong character is lost, or a character is duplicated within three pops. A wrong head-arrival decision corrupts the accumulated flags, and that shows only in accumulate mode and persists until the next clear. Because of this, the bench compares every output against a reference model on every cycle, in both modes.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 3;  // bit0 parity, bit1 framing, bit2 break

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [DATA_W-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rxb_fifo.sv
module rxb_fifo
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  rx_char_t                     push_char_i,
  input  logic                         pop_i,
  output rx_char_t                     head_o,
  output logic [FLAG_W-1:0]            next_flags_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         full_next_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  rx_char_t       mem_q [DEPTH];
  logic [PW-1:0]  rd_q, wr_q, rd_nx;
  logic [CW-1:0]  cnt_q, cnt_d;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign rd_nx        = inc(rd_q);
  assign head_o       = mem_q[rd_q];
  assign next_flags_o = mem_q[rd_nx].flags;
  assign count_o      = cnt_q;
  assign full_o       = (cnt_q == FULL_CNT);
  assign empty_o      = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + CW'(1);
    else if (pop_i && !push_i) cnt_d = cnt_q - CW'(1);
  end
  assign full_next_o = (cnt_d == FULL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= rd_nx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && wr_q == PW'(g)) mem_q[g] <= push_char_i;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  // R12
  swap_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(count_o));
endmodule

// File: rtl/rxb_slot.sv
module rxb_slot
  import uart_rxb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     done_i,
  input  rx_char_t char_i,
  input  logic     start_i,
  input  logic     fifo_full_i,
  input  logic     pop_i,
  input  logic     clr_i,
  output rx_char_t slot_o,
  output logic     drain_o,
  output logic     ovr_o
);
  rx_char_t slot_q;
  logic     valid_q, ovr_q;

  assign drain_o = valid_q && !fifo_full_i;
  assign slot_o  = slot_q;
  assign ovr_o   = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      // a new character replaces one still waiting on a full FIFO
      if (done_i) begin
        slot_q  <= char_i;
        valid_q <= 1'b1;
      end else if (drain_o) begin
        valid_q <= 1'b0;
      end
      ovr_q <= (ovr_q && !clr_i) ||
               (start_i && valid_q && fifo_full_i && !pop_i);
    end
  end

  // R5
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(start_i && valid_q && fifo_full_i));
  // R4
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && fifo_full_i) |=> valid_q);
endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import uart_rxb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_mode_i,
  input  logic              clr_i,
  input  logic              arrive_i,
  input  logic [FLAG_W-1:0] arrive_flags_i,
  input  logic [FLAG_W-1:0] head_flags_i,
  input  logic              empty_i,
  input  logic              full_i,
  input  logic              full_next_i,
  input  logic              pop_i,
  input  logic              start_i,
  input  logic              irq_sel_i,
  input  logic              auto_rts_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              ready_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              rts_o
);
  logic [FLAG_W-1:0] acc_q;
  logic              rts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rts_q <= 1'b1;
    end else begin
      acc_q <= (clr_i ? '0 : acc_q) | (arrive_i ? arrive_flags_i : '0);
      if (!auto_rts_i)                       rts_q <= 1'b1;
      else if (start_i && full_i && !pop_i)  rts_q <= 1'b0;
      else if (!full_next_i)                 rts_q <= 1'b1;
    end
  end

  assign ready_o = !empty_i;
  assign full_o  = full_i;
  assign flags_o = blk_mode_i ? acc_q : (empty_i ? '0 : head_flags_i);
  assign irq_o   = irq_sel_i ? full_i : !empty_i;
  assign rts_o   = rts_q;

  // R11
  rts_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rts_o) |-> $past(start_i && full_i && auto_rts_i));
  // R3
  full_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ready_o);
  // R7
  acc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_q[0]) |=> acc_q[0]);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] char_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              brk_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              blk_mode_i,
  input  logic              clr_err_i,
  input  logic              irq_sel_i,
  input  logic              auto_rts_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              full_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              brk_o,
  output logic              ovr_o,
  output logic              irq_o,
  output logic              rts_o
);
  localparam int CW = $clog2(DEPTH+1);

  rx_char_t          in_char, slot_char, head;
  logic [FLAG_W-1:0] next_flags, flags, arr_flags;
  logic [CW-1:0]     count;
  logic              pop, drain, fifo_full, fifo_empty, full_next, arrive;
  logic [DATA_W-1:0] last_q;

  assign in_char = '{flags: {brk_i, fe_i, pe_i}, data: char_i};
  assign pop     = rd_i && !fifo_empty;

  rxb_slot u_slot (
    .clk_i, .rst_ni,
    .done_i, .char_i(in_char), .start_i,
    .fifo_full_i(fifo_full), .pop_i(pop), .clr_i(clr_err_i),
    .slot_o(slot_char), .drain_o(drain), .ovr_o
  );

  rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(drain), .push_char_i(slot_char), .pop_i(pop),
    .head_o(head), .next_flags_o(next_flags), .count_o(count),
    .full_o(fifo_full), .empty_o(fifo_empty), .full_next_o(full_next)
  );

  // a character becomes head when a pop exposes the next entry,
  // or when a push lands in a FIFO that is (or becomes) empty
  always_comb begin
    arrive    = 1'b0;
    arr_flags = slot_char.flags;
    if (pop && count >= CW'(2)) begin
      arrive    = 1'b1;
      arr_flags = next_flags;
    end else if (drain && (fifo_empty || (pop && count == CW'(1)))) begin
      arrive    = 1'b1;
    end
  end

  rxb_status u_stat (
    .clk_i, .rst_ni,
    .blk_mode_i, .clr_i(clr_err_i),
    .arrive_i(arrive), .arrive_flags_i(arr_flags), .head_flags_i(head.flags),
    .empty_i(fifo_empty), .full_i(fifo_full), .full_next_i(full_next),
    .pop_i(pop), .start_i, .irq_sel_i, .auto_rts_i,
    .flags_o(flags), .ready_o, .full_o, .irq_o, .rts_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= '0;
    else if (pop) last_q <= head.data;
  end

  assign data_o = fifo_empty ? last_q : head.data;
  assign pe_o   = flags[0];
  assign fe_o   = flags[1];
  assign brk_o  = flags[2];

  // R9
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fifo_empty && !drain) |=> ($stable(data_o) && !ready_o));
  // R8
  clr_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !start_i) |=> !ovr_o);
endmodule

// File: tb/uart_rx_buffer_test.sv
module uart_rx_buffer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 0, start = 0, rd = 0, clr = 0, blk = 0, isel = 0, arts = 1;
  logic [7:0] chr = 0;
  logic [2:0] fl = 0;
  logic [7:0] data_o;
  logic ready_o, full_o, pe_o, fe_o, brk_o, ovr_o, irq_o, rts_o;
  int checks = 0, errors = 0;

  // reference model state
  logic [10:0] q [3];
  int          cnt;
  logic [10:0] slot_m;
  logic        slot_v, ovr_m, rts_m;
  logic [2:0]  acc_m;
  logic [7:0]  last_m;

  always #10 clk = ~clk;

  uart_rx_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .char_i(chr),
    .pe_i(fl[0]), .fe_i(fl[1]), .brk_i(fl[2]), .start_i(start), .rd_i(rd),
    .blk_mode_i(blk), .clr_err_i(clr), .irq_sel_i(isel), .auto_rts_i(arts),
    .data_o, .ready_o, .full_o, .pe_o, .fe_o, .brk_o, .ovr_o, .irq_o, .rts_o
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    cnt = 0; slot_v = 0; slot_m = 0; ovr_m = 0; rts_m = 1; acc_m = 0; last_m = 0;
    for (int i = 0; i < 3; i++) q[i] = 0;
  endtask

  function automatic logic [2:0] exp_flags();
    if (blk) return acc_m;
    return (cnt == 0) ? 3'b000 : q[0][10:8];
  endfunction

  task automatic model_edge();
    logic pop, drain, head_chg;
    logic [2:0] arr;
    pop   = rd && cnt > 0;
    drain = slot_v && cnt < 3;
    ovr_m = (ovr_m && !clr) || (start && slot_v && cnt == 3 && !pop);
    if (arts && start && cnt == 3 && !pop) rts_m = 0;
    if (pop) begin
      last_m = q[0][7:0];
      q[0] = q[1]; q[1] = q[2];
      cnt--;
    end
    head_chg = pop || (cnt == 0 && drain);
    if (drain) begin q[cnt] = slot_m; cnt++; end
    arr = (head_chg && cnt > 0) ? q[0][10:8] : 3'b000;
    acc_m = (clr ? 3'b000 : acc_m) | arr;
    if (!arts) rts_m = 1;
    else if (!(start && (cnt - (drain ? 1 : 0) + (pop ? 1 : 0)) == 3 && !pop) && cnt < 3)
      rts_m = 1;
    if (done) begin slot_m = {fl, chr}; slot_v = 1; end
    else if (drain) slot_v = 0;
  endtask

  task automatic compare_all();
    logic [2:0] ef;
    ef = exp_flags();
    chk(data_o == ((cnt > 0) ? q[0][7:0] : last_m), "R2", "data_o", data_o,
        (cnt > 0) ? q[0][7:0] : last_m);
    chk(ready_o == (cnt > 0), "R3", "ready_o", ready_o, cnt > 0);
    chk(full_o == (cnt == 3), "R3", "full_o", full_o, cnt == 3);
    chk({brk_o, fe_o, pe_o} == ef, blk ? "R7" : "R6", "flags",
        {brk_o, fe_o, pe_o}, ef);
    chk(ovr_o == ovr_m, "R5", "ovr_o", ovr_o, ovr_m);
    chk(irq_o == (isel ? (cnt == 3) : (cnt > 0)), "R10", "irq_o", irq_o,
        isel ? (cnt == 3) : (cnt > 0));
    chk(rts_o == rts_m, "R11", "rts_o", rts_o, rts_m);
  endtask

  // drive after a falling edge, model the rising edge, compare at the next fall
  task automatic step(input logic d, input logic [7:0] c, input logic [2:0] f,
                      input logic s, input logic r, input logic cl);
    done = d; chr = c; fl = f; start = s; rd = r; clr = cl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    done = 0; start = 0; rd = 0; clr = 0;
    compare_all();
  endtask

  task automatic idle(); step(0, 8'h00, 3'b000, 0, 0, 0); endtask

  initial begin
    #(4_000_000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!ready_o && !full_o && !pe_o && !fe_o && !brk_o && !ovr_o && !irq_o,
        "R1", "status after reset", {ready_o, full_o, ovr_o, irq_o}, 0);
    chk(rts_o == 1'b1 && data_o == 8'h00, "R1", "rts/data after reset",
        {rts_o, data_o}, 9'h100);

    // R9 read of an empty buffer
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(!ready_o && data_o == 8'h00, "R9", "empty read", data_o, 0);

    // R2/R4 fill: three in FIFO, one waiting
    step(1, 8'hA0, 3'b001, 0, 0, 0);
    chk(!ready_o, "R2", "ready one edge after strobe", ready_o, 0);
    step(1, 8'hA1, 3'b000, 0, 0, 0);
    chk(ready_o, "R2", "ready two edges after strobe", ready_o, 1);
    step(1, 8'hA2, 3'b010, 0, 0, 0);
    step(1, 8'hA3, 3'b100, 0, 0, 0);
    chk(full_o, "R3", "full with three entries", full_o, 1);
    // R5/R11 start bit while full with a waiting character
    step(0, 8'h00, 3'b000, 1, 0, 0);
    chk(ovr_o, "R5", "overrun set on start bit", ovr_o, 1);
    chk(!rts_o, "R11", "rts dropped", rts_o, 0);
    step(1, 8'hA4, 3'b000, 0, 0, 0);
    chk(data_o == 8'hA0 && full_o, "R5", "FIFO unchanged by overrun", data_o, 8'hA0);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(rts_o && !full_o, "R11", "rts back after pop", rts_o, 1);
    idle();
    chk(full_o, "R4", "waiting char moved in after pop", full_o, 1);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(data_o == 8'hA2, "R2", "second pop order", data_o, 8'hA2);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(data_o == 8'hA4, "R5", "replacement kept, A3 lost", data_o, 8'hA4);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(!ready_o && data_o == 8'hA4, "R9", "last value held when empty", data_o, 8'hA4);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(!ready_o && data_o == 8'hA4, "R9", "extra read ignored", data_o, 8'hA4);

    // R12 pop and slot move on one edge
    step(1, 8'hB0, 3'b000, 0, 0, 0);
    idle();
    step(1, 8'hB1, 3'b010, 0, 0, 0);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(ready_o && data_o == 8'hB1, "R12", "pop with push", data_o, 8'hB1);
    chk(fe_o, "R6", "head flags in char mode", fe_o, 1);
    step(0, 8'h00, 3'b000, 0, 1, 0);

    // R8 clear with same-edge head arrival, accumulate mode
    blk = 1;
    step(1, 8'hC0, 3'b001, 0, 0, 0);
    step(0, 8'h00, 3'b000, 0, 0, 1);
    chk(pe_o && !ovr_o, "R8", "arrival flags kept over clear", {pe_o, ovr_o}, 2'b10);
    step(0, 8'h00, 3'b000, 0, 1, 0);
    chk(pe_o && !ready_o, "R7", "accumulated flag survives pop", pe_o, 1);
    step(0, 8'h00, 3'b000, 0, 0, 1);
    chk(!pe_o, "R8", "clear drops accumulated flag", pe_o, 0);

    // random traffic
    for (int blkn = 0; blkn < 20; blkn++) begin
      int prd;
      prd  = 10 + (blkn % 5) * 20;
      blk  = blkn[0];
      isel = blkn[1];
      arts = (blkn % 7) != 3;
      for (int i = 0; i < 150; i++) begin
        step(($urandom % 100) < 40, 8'($urandom), 3'($urandom),
             ($urandom % 100) < 30, ($urandom % 100) < prd,
             ($urandom % 100) < 4);
      end
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule